// File: doc/BRIEF.md
# Protection-Region Lookup with Subregion Masking

This block classifies each 32-bit data access against a small set of programmable protection regions. A region is set up through a base word and an attribute word. The attribute word holds an enable bit, a size exponent, an eight-bit mask that removes subregions, and a memory class. For every access the block returns the class of the highest-numbered enabled region that covers the address. It also reports whether the access must be refused for alignment, or because no region covers it.

Each region is split into eight equal subregions. When a subregion is masked out, addresses inside it are no longer claimed by that region. They drop to the next covering region of lower number. That region is often a catch-all background region of a strict class, and a strict class refuses unaligned accesses. This is how a mask that was set up wrongly shows up as alignment faults in only part of a memory.

The result is registered: an access presented on one clock edge is classified at the next edge. The class encoding is 0 strongly-ordered, 1 device, 2 normal and 3 reserved (treated as strict). The access size encoding is 0 byte, 1 halfword, 2 word and 3 treated as word.

Top module: `mpu_lookup`

## Requirements
- R1: After reset every region is disabled and all result outputs are zero. With the unit enabled, the first access after reset reports a miss.
- R2: A size field S selects a region of 2^(S+1) bytes. Matching ignores the low S+1 bits of the programmed base. Attribute word layout: bit 0 enable, bits 5:1 size S, bits 15:8 subregion mask, bits 17:16 class.
- R3: Mask bit n removes subregion n, counted upward from the matched base. Each subregion is one eighth of the region. An address in a removed subregion is not claimed by that region.
- R4: When several enabled regions cover an address, the highest-numbered one wins. Its number and class are reported with res_hit set.
- R5: A region whose enable bit is clear, or whose size field is below 4, never matches.
- R6: An unaligned access that resolves to a class other than normal (0, 1 or 3) raises res_align_fault.
- R7: An unaligned access that resolves to normal memory raises res_align_fault only when trap_unaligned is set.
- R8: A word access is unaligned when address bits 1:0 are not zero. A halfword access is unaligned when address bit 0 is set. A byte access is never unaligned.
- R9: With the unit enabled and no region covering the address, res_miss_fault is set, res_hit is clear, the class reads 0 and res_align_fault is clear.
- R10: With mpu_en clear, the result is class normal with res_hit and res_miss_fault clear and region 0. res_align_fault follows R7 alone.
- R11: Each result appears one clock edge after its access is presented. A configuration write is in effect for accesses presented in the cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Region number to write |
| cfg_field | input | 1 | 0 writes the base word, 1 writes the attribute word |
| cfg_data | input | 32 | Word to write |
| mpu_en | input | 1 | Unit enable |
| trap_unaligned | input | 1 | Refuse unaligned accesses to normal memory |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 word |
| res_hit | output | 1 | A region covered the access |
| res_region | output | IDX_W | Number of the winning region |
| res_type | output | 2 | Resolved memory class |
| res_align_fault | output | 1 | Access refused for alignment |
| res_miss_fault | output | 1 | No region covered the access |

## Verification
The bench builds the block with four regions. That is enough for a background region, a masked memory region, a smaller overlapping region of higher priority, and a spare region used for the size-below-4 case. With this small setup, each configuration can be swept over a 160 KB window at 4 KB steps, with every byte offset 0 to 3 and all three access sizes. The sweep crosses every subregion boundary of a 128 KB region and runs past its end. The expected values come from an arithmetic model of range, subregion index and alignment.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

   localparam int unsigned ADDR_W = 32;
   localparam int unsigned SIZE_W = 5;

   // attribute word field positions
   localparam int unsigned AT_EN      = 0;
   localparam int unsigned AT_SIZE_LO = 1;
   localparam int unsigned AT_SRD_LO  = 8;
   localparam int unsigned AT_TYP_LO  = 16;
   localparam int unsigned MIN_SIZE   = 4;

   typedef enum logic [1:0] {
      MT_STRONG = 2'd0,
      MT_DEVICE = 2'd1,
      MT_NORMAL = 2'd2,
      MT_RSVD   = 2'd3
   } mem_type_e;

   typedef enum logic [1:0] {
      AS_BYTE = 2'd0,
      AS_HALF = 2'd1,
      AS_WORD = 2'd2,
      AS_WRD3 = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic              en;
      logic [SIZE_W-1:0] size;
      logic [7:0]        srd;
      mem_type_e         typ;
   } region_attr_t;

   function automatic region_attr_t unpack_attr(input logic [31:0] w);
      region_attr_t a;
      a.en   = w[AT_EN];
      a.size = w[AT_SIZE_LO +: SIZE_W];
      a.srd  = w[AT_SRD_LO +: 8];
      a.typ  = mem_type_e'(w[AT_TYP_LO +: 2]);
      return a;
   endfunction

endpackage

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
   import mpu_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
)(
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [IDX_W-1:0]                       wr_idx,
   input  logic                                   wr_field,
   input  logic [31:0]                            wr_data,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     base_o,
   output region_attr_t [NUM_REGIONS-1:0]         attr_o
);

   for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_reg
      logic [ADDR_W-1:0] base_q;
      logic [31:0]       attr_q;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(gi));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            attr_q <= '0;
         end else if (sel) begin
            if (wr_field) attr_q <= wr_data;
            else          base_q <= wr_data;
         end
      end

      assign base_o[gi] = base_q;
      assign attr_o[gi] = unpack_attr(attr_q);
   end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
   import mpu_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  region_attr_t      attr,
   output logic              hit
);

   logic              live;
   logic [5:0]        span_sh;
   logic [SIZE_W-1:0] sub_sh;
   logic [ADDR_W-1:0] upper_diff;
   logic [2:0]        sub_idx;

   always_comb begin
      live       = attr.en && (attr.size >= SIZE_W'(MIN_SIZE));
      span_sh    = 6'(attr.size) + 6'd1;
      sub_sh     = attr.size - SIZE_W'(2);
      upper_diff = (addr ^ base) >> span_sh;
      sub_idx    = 3'(addr >> sub_sh);
      hit        = live && (upper_diff == '0) && !attr.srd[sub_idx];
   end

endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
   parameter int unsigned NUM_REGIONS = 8,
   localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
)(
   input  logic [NUM_REGIONS-1:0] hits,
   output logic                   found,
   output logic [IDX_W-1:0]       idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hits[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mpu_align_judge.sv
module mpu_align_judge
   import mpu_pkg::*;
(
   input  logic [1:0] addr_lo,
   input  acc_size_e  size,
   output logic       unaligned
);

   always_comb begin
      unique case (size)
         AS_BYTE:         unaligned = 1'b0;
         AS_HALF:         unaligned = addr_lo[0];
         AS_WORD, AS_WRD3: unaligned = (addr_lo != 2'b00);
         default:         unaligned = 1'b0;
      endcase
   end

endmodule

// File: rtl/mpu_lookup.sv
module mpu_lookup
   import mpu_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_field,
   input  logic [31:0]       cfg_data,
   input  logic              mpu_en,
   input  logic              trap_unaligned,
   input  logic [31:0]       acc_addr,
   input  logic [1:0]        acc_size,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_region,
   output logic [1:0]        res_type,
   output logic              res_align_fault,
   output logic              res_miss_fault
);

   if (NUM_REGIONS < 1 || NUM_REGIONS > 16) begin : g_bad_count
      $error("mpu_lookup: NUM_REGIONS must lie in 1..16");
   end
   if (ADDR_W != 32) begin : g_bad_width
      $error("mpu_lookup: address width must be 32");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_w;
   region_attr_t [NUM_REGIONS-1:0]     attr_w;
   logic [NUM_REGIONS-1:0]             hit_w;
   logic                               found_w;
   logic [IDX_W-1:0]                   idx_w;
   logic                               unal_w;
   mem_type_e                          win_typ;

   mpu_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_field (cfg_field),
      .wr_data  (cfg_data),
      .base_o   (base_w),
      .attr_o   (attr_w)
   );

   for (genvar gr = 0; gr < NUM_REGIONS; gr++) begin : g_match
      mpu_region_match u_match (
         .addr (acc_addr),
         .base (base_w[gr]),
         .attr (attr_w[gr]),
         .hit  (hit_w[gr])
      );
   end

   mpu_prio_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
      .hits  (hit_w),
      .found (found_w),
      .idx   (idx_w)
   );

   mpu_align_judge u_align (
      .addr_lo   (acc_addr[1:0]),
      .size      (acc_size_e'(acc_size)),
      .unaligned (unal_w)
   );

   assign win_typ = attr_w[idx_w].typ;

   logic             nx_hit, nx_align, nx_miss;
   logic [IDX_W-1:0] nx_region;
   logic [1:0]       nx_type;

   always_comb begin
      nx_hit    = 1'b0;
      nx_region = '0;
      nx_type   = MT_STRONG;
      nx_align  = 1'b0;
      nx_miss   = 1'b0;
      if (!mpu_en) begin
         nx_type  = MT_NORMAL;
         nx_align = unal_w && trap_unaligned;
      end else if (!found_w) begin
         nx_miss = 1'b1;
      end else begin
         nx_hit    = 1'b1;
         nx_region = idx_w;
         nx_type   = win_typ;
         nx_align  = unal_w && ((win_typ != MT_NORMAL) || trap_unaligned);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_hit         <= 1'b0;
         res_region      <= '0;
         res_type        <= '0;
         res_align_fault <= 1'b0;
         res_miss_fault  <= 1'b0;
      end else begin
         res_hit         <= nx_hit;
         res_region      <= nx_region;
         res_type        <= nx_type;
         res_align_fault <= nx_align;
         res_miss_fault  <= nx_miss;
      end
   end

endmodule

// File: rtl/mpu_lookup_chk.sv
module mpu_lookup_chk #(
   parameter int unsigned NUM_REGIONS = 8,
   localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              mpu_en,
   input logic              trap_unaligned,
   input logic [31:0]       acc_addr,
   input logic [1:0]        acc_size,
   input logic              res_hit,
   input logic [IDX_W-1:0]  res_region,
   input logic [1:0]        res_type,
   input logic              res_align_fault,
   input logic              res_miss_fault
);

   logic seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({res_hit, res_miss_fault}) <= 1 && !(res_miss_fault && res_align_fault));

   assert_miss_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss_fault |-> res_type == 2'd0);

   assert_byte_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && $past(acc_size) == 2'd0 |-> !res_align_fault);

   assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && $past(acc_addr[1:0]) == 2'b00 |-> !res_align_fault);

   assert_off_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && !$past(mpu_en) |-> res_type == 2'd2 && !res_hit && !res_miss_fault);

   assert_strict_unaligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && res_hit && res_type != 2'd2 && $past(acc_size) == 2'd2
         && $past(acc_addr[1:0]) != 2'b00 |-> res_align_fault);

   assert_normal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && res_type == 2'd2 && !$past(trap_unaligned) |-> !res_align_fault);

endmodule

bind mpu_lookup mpu_lookup_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .mpu_en          (mpu_en),
   .trap_unaligned  (trap_unaligned),
   .acc_addr        (acc_addr),
   .acc_size        (acc_size),
   .res_hit         (res_hit),
   .res_region      (res_region),
   .res_type        (res_type),
   .res_align_fault (res_align_fault),
   .res_miss_fault  (res_miss_fault)
);

// File: tb/mpu_lookup_tb.sv
module mpu_lookup_tb;

   localparam int NR = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic          cfg_field = 1'b0;
   logic [31:0]   cfg_data = '0;
   logic          mpu_en = 1'b1;
   logic          trap_unaligned = 1'b0;
   logic [31:0]   acc_addr = '0;
   logic [1:0]    acc_size = '0;
   logic          res_hit;
   logic [IW-1:0] res_region;
   logic [1:0]    res_type;
   logic          res_align_fault;
   logic          res_miss_fault;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_base [NR];
   logic [31:0] m_attr [NR];

   always #2 clk = ~clk;

   mpu_lookup #(.NUM_REGIONS(NR)) u_dut (.*);

   function automatic logic [31:0] mk_attr(input logic en, input int s,
                                           input logic [7:0] srd, input int typ);
      return {14'b0, 2'(typ), srd, 2'b0, 5'(s), en};
   endfunction

   // {hit, region[1:0], type[1:0], align, miss}
   function automatic logic [6:0] model(input logic [31:0] a, input int sz);
      logic unal;
      int   win;
      if (sz == 0)      unal = 1'b0;
      else if (sz == 1) unal = (a % 2) != 0;
      else              unal = (a % 4) != 0;
      if (!mpu_en) return {1'b0, 2'd0, 2'd2, unal && trap_unaligned, 1'b0};
      win = -1;
      for (int r = 0; r < NR; r++) begin
         longint span, lo, off;
         int     s, sub;
         s = int'(m_attr[r][5:1]);
         if (m_attr[r][0] && s >= 4) begin
            span = longint'(1) << (s + 1);
            lo   = longint'(m_base[r]) - (longint'(m_base[r]) % span);
            off  = longint'(a) - lo;
            if (off >= 0 && off < span) begin
               sub = int'(off / (span / 8));
               if (!m_attr[r][8 + sub]) win = r;
            end
         end
      end
      if (win < 0) return {1'b0, 2'd0, 2'd0, 1'b0, 1'b1};
      begin
         int t;
         t = int'(m_attr[win][17:16]);
         return {1'b1, 2'(win), 2'(t), unal && (t != 2 || trap_unaligned), 1'b0};
      end
   endfunction

   task automatic cfg(input int r, input logic [31:0] b, input logic [31:0] at);
      m_base[r] = b;
      m_attr[r] = at;
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(r); cfg_field = 1'b0; cfg_data = b;
      @(negedge clk);
      cfg_field = 1'b1; cfg_data = at;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic check(input string tag, input logic [31:0] a, input int sz);
      logic [6:0] got, exp;
      exp = model(a, sz);
      @(negedge clk);
      acc_addr = a; acc_size = 2'(sz);
      @(negedge clk);
      got = {res_hit, res_region, res_type, res_align_fault, res_miss_fault};
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h size=%0d got=%b exp=%b", tag, a, sz, got, exp);
      end
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k < 40; k++)
         for (int o = 0; o < 4; o++)
            for (int s = 0; s < 3; s++)
               check(tag, 32'h2040_0000 + 32'(k) * 32'h1000 + 32'(o), s);
   endtask

   initial begin
      for (int r = 0; r < NR; r++) begin m_base[r] = '0; m_attr[r] = '0; end
      repeat (3) @(negedge clk);
      n_cmp++;
      if ({res_hit, res_region, res_type, res_align_fault, res_miss_fault} !== 7'd0) begin
         n_bad++;
         $display("FAIL R1 reset outputs got=%b exp=0",
                  {res_hit, res_region, res_type, res_align_fault, res_miss_fault});
      end
      rst_n = 1'b1;
      check("R1", 32'h2040_0000, 2);
      // background strict region plus masked normal memory
      cfg(0, 32'h0, mk_attr(1, 31, 8'h00, 0));
      cfg(1, 32'h2040_0000, mk_attr(1, 16, 8'hF8, 2));
      sweep("R3");
      cfg(1, 32'h2040_0000, mk_attr(1, 16, 8'hC0, 2));
      sweep("R2");
      cfg(1, 32'h2040_1234, mk_attr(1, 16, 8'h00, 2));
      sweep("R2");
      cfg(2, 32'h2041_0000, mk_attr(1, 12, 8'h00, 1));
      sweep("R4");
      cfg(2, 32'h2041_0000, mk_attr(1, 12, 8'h02, 3));
      sweep("R6");
      trap_unaligned = 1'b1;
      sweep("R7");
      trap_unaligned = 1'b0;
      cfg(3, 32'h2040_0000, mk_attr(1, 3, 8'h00, 1));
      cfg(1, 32'h2040_0000, mk_attr(0, 16, 8'h00, 2));
      sweep("R5");
      cfg(1, 32'h2040_0000, mk_attr(1, 16, 8'h30, 2));
      cfg(0, 32'h0, mk_attr(0, 31, 8'h00, 0));
      sweep("R9");
      check("R8", 32'h2040_0002, 1);
      check("R8", 32'h2040_0001, 1);
      mpu_en = 1'b0;
      sweep("R10");
      trap_unaligned = 1'b1;
      sweep("R10");
      mpu_en = 1'b1; trap_unaligned = 1'b0;
      // R11: write then access in the next cycle
      cfg(0, 32'h0, mk_attr(1, 31, 8'h00, 1));
      check("R11", 32'h3000_0003, 2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule